// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets an on-chip requester read and write an external memory through a single set of shared address/data lines. At the start of a bus cycle the lines carry the address, which an external transparent latch captures on the falling edge of the address latch enable. The lines then either carry write data from the master or are released so that the memory can drive read data back.

A bus cycle consists of an address part of `A_PH` bus-clock periods and a data part of `B_PH` bus-clock periods, with both parts at least 1. The controller is clocked at twice the bus-clock rate. Every one of its clock cycles is therefore one half period of the bus clock, and each strobe edge lands on a half-period boundary derived from the two parameters. The defaults give a 2+2 cycle.

On the core side the requester presents a direction, an address, write data and a high-byte flag together with `req`. The request is taken on a clock edge where `req_ready` is high. When the cycle completes, `done` pulses for one cycle and read data is available on `rdata`.

Top module: `mux_bus_master`

## Requirements
- R1: While `rst` is high, `cs_n`, `rd_n`, `wr_n` and `bhe_n` are 1, `ale` and `ad_oe` are 0, and `req_ready` is 0.
- R2: Number the half periods of a cycle t = 0 .. 2(A_PH+B_PH)-1, where t = 0 is the first clock cycle after the accepting edge. `ale` is 1 for t < A_PH and 0 afterwards. `ad_out` carries the request address with `ad_oe` = 1 for all t < 2*A_PH, so the address is valid for A_PH half periods on each side of the falling edge of `ale`.
- R3: The strobe (`rd_n` for reads, `wr_n` for writes) is 0 for exactly 2*B_PH-1 half periods, from t = 2*A_PH through t = 2(A_PH+B_PH)-2. The other strobe stays at 1.
- R4: In a read cycle, `ad_oe` is 0 from t = 2*A_PH to the end of the cycle, and `ad_oe` is never 1 while `rd_n` is 0.
- R5: Read data is sampled from `ad_in` on the clock edge that ends the last strobe half period, which is 2(A_PH+B_PH-1)+1 half periods after the address first appears. It is presented on `rdata`, with `done` = 1, for the single clock cycle that follows the end of the bus cycle.
- R6: `cs_n` is 0 for the whole cycle, 2(A_PH+B_PH) half periods in total. This includes the final half period after the strobe rises, during which chip select, the high-byte flag and write data are held.
- R7: In a write cycle, `ad_out` carries the write data with `ad_oe` = 1 from t = 2*A_PH through the last half period.
- R8: `bhe_n` is 0 for the whole cycle when the request's high-byte flag is 1, and 1 otherwise.
- R9: `req_ready` is 1 only when no cycle is in progress. A request that is held high starts its next cycle only after `cs_n` has been 1 for at least one half period.
- R10: `bclk` toggles on every clock cycle and is 1 at every even t, so each cycle begins on a rising edge of the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, twice the bus-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Cycle request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AD_W | Cycle address |
| req_wdata | input | AD_W | Write data |
| req_bhe | input | 1 | High-byte access flag |
| req_ready | output | 1 | Request is taken on this edge when `req` is high |
| done | output | 1 | One-cycle pulse after a cycle ends |
| rdata | output | AD_W | Captured read data |
| bclk | output | 1 | Bus clock |
| cs_n | output | 1 | Chip select, active low |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| ad_out | output | AD_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | AD_W | Value seen on the shared lines |

## Verification
The bench waits for `req_ready` at a falling clock edge, and the accepting rising edge follows. From the very next falling edge it samples every pin once per half period. Each sample is compared against the value that R2 through R10 give for that index t.

With no extra registers in the path, the pins for half period t are due exactly t+1 edges after acceptance. `done` and `rdata` are due one falling edge after half period 2(A_PH+B_PH)-1.

Three instances (2+2, 1+3 and 3+1) each run against a latch-and-memory model, so the strobe and hold windows are checked at their extremes. A monitor flags any half period in which the master drives the lines while `rd_n` is low.

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
  parameter int AD_W = 16,
  parameter int A_PH = 2,
  parameter int B_PH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            req_we,
  input  logic [AD_W-1:0] req_addr,
  input  logic [AD_W-1:0] req_wdata,
  input  logic            req_bhe,
  output logic            req_ready,
  output logic            done,
  output logic [AD_W-1:0] rdata,
  output logic            bclk,
  output logic            cs_n,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            bhe_n,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_oe,
  input  logic [AD_W-1:0] ad_in
);

  localparam int HP_TOTAL = 2 * (A_PH + B_PH);
  localparam int CW = $clog2(HP_TOTAL);
  localparam logic [CW-1:0] ALE_END  = CW'(A_PH);
  localparam logic [CW-1:0] ADDR_END = CW'(2 * A_PH);
  localparam logic [CW-1:0] LAST     = CW'(HP_TOTAL - 1);
  localparam logic [CW-1:0] SAMPLE   = CW'(HP_TOTAL - 2);

  logic            busy, ph, we_q, bhe_q, done_q;
  logic [CW-1:0]   cnt;
  logic [AD_W-1:0] addr_q, wdata_q, rdata_q;

  assign req_ready = !busy && !ph && !rst;
  wire take = req && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ph      <= 1'b0;
      cnt     <= '0;
      we_q    <= 1'b0;
      bhe_q   <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ph     <= ~ph;
      done_q <= busy && (cnt == LAST);
      if (take) begin
        busy    <= 1'b1;
        cnt     <= '0;
        we_q    <= req_we;
        bhe_q   <= req_bhe;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else if (busy) begin
        if (cnt == LAST) busy <= 1'b0;
        else             cnt  <= cnt + 1'b1;
      end
      if (busy && !we_q && cnt == SAMPLE) rdata_q <= ad_in;
    end
  end

  wire in_addr = busy && (cnt < ADDR_END);
  wire in_strb = busy && (cnt >= ADDR_END) && (cnt < LAST);

  assign bclk   = ph;
  assign cs_n   = !busy;
  assign ale    = busy && (cnt < ALE_END);
  assign rd_n   = !(in_strb && !we_q);
  assign wr_n   = !(in_strb && we_q);
  assign bhe_n  = !(busy && bhe_q);
  assign ad_oe  = in_addr || (busy && we_q);
  assign ad_out = !busy ? '0 : (in_addr ? addr_q : wdata_q);
  assign done   = done_q;
  assign rdata  = rdata_q;

  a_r2_addr_across_ale: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (ad_oe && $stable(ad_out)));
  a_r4_bus_released: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  a_r6_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) || $rose(wr_n)) |-> (!cs_n && $stable(bhe_n) && $stable(ad_out)));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_idle_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);
  a_r10_bclk_toggle: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (bclk != $past(bclk)));

endmodule

// File: tb/mux_bus_master_bench.sv
`timescale 1ns/1ps
module mux_bus_rig #(parameter int A = 2, parameter int B = 2) (
  input logic clk,
  input logic rst
);
  localparam int HP = 2 * (A + B);

  logic        req = 0, req_we = 0, req_bhe = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic        req_ready, done, bclk, cs_n, ale, rd_n, wr_n, bhe_n, ad_oe;
  logic [15:0] rdata, ad_out, ad_in;
  logic [15:0] mem [0:255];
  logic [15:0] shadow [0:255];
  logic [7:0]  lat = 0;
  int n_chk = 0, n_bad = 0, clash = 0;
  bit fin = 0;

  assign ad_in = ad_oe ? ad_out : (!rd_n ? mem[lat] : 16'h0);

  mux_bus_master #(.AD_W(16), .A_PH(A), .B_PH(B)) u_mux_bus_master (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_bhe(req_bhe), .req_ready(req_ready),
    .done(done), .rdata(rdata), .bclk(bclk), .cs_n(cs_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in));

  always @(negedge ale) lat <= ad_in[7:0];
  always @(posedge wr_n) if (!rst) mem[lat] <= ad_in;
  always @(negedge clk) if (!rst && !rd_n && ad_oe) clash++;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (a=%0d b=%0d) %s: actual %0h expected %0h", rq, A, B, what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(rst && cs_n && !ale && rd_n && wr_n && bhe_n && !ad_oe && !req_ready,
        "R1", "idle pins in reset",
        {cs_n, ale, rd_n, wr_n, bhe_n, ad_oe, req_ready}, 7'b1011100);
  endtask

  task automatic t_cycle(input bit we, input logic [15:0] addr,
                         input logic [15:0] wd, input bit bhe);
    int m2 = 0, m3 = 0, m4 = 0, m6 = 0, m7 = 0, m8 = 0, m10 = 0;
    int n_ale = 0, n_strb = 0;
    @(negedge clk);
    req = 1; req_we = we; req_addr = addr; req_wdata = wd; req_bhe = bhe;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req = 0;
    for (int t = 0; t < HP; t++) begin
      if (t > 0) @(negedge clk);
      if (ale != (t < A)) m2++;
      if (t < 2 * A && (!ad_oe || ad_out != addr)) m2++;
      if (ale) n_ale++;
      if (rd_n != !(!we && t >= 2 * A && t < HP - 1)) m3++;
      if (wr_n != !(we && t >= 2 * A && t < HP - 1)) m3++;
      if (!(we ? wr_n : rd_n)) n_strb++;
      if (!we && t >= 2 * A && ad_oe) m4++;
      if (cs_n) m6++;
      if (we && t >= 2 * A && (!ad_oe || ad_out != wd)) m7++;
      if (bhe_n != !bhe) m8++;
      if (bclk != (t % 2 == 0)) m10++;
    end
    chk(m2 == 0, "R2", "bad address/ale half periods", m2, 0);
    chk(n_ale == A, "R2", "ale width", n_ale, A);
    chk(m3 == 0, "R3", "bad strobe half periods", m3, 0);
    chk(n_strb == 2 * B - 1, "R3", "strobe width", n_strb, 2 * B - 1);
    if (!we) chk(m4 == 0, "R4", "driven in read window", m4, 0);
    chk(m6 == 0, "R6", "cs_n high inside cycle", m6, 0);
    if (we) chk(m7 == 0, "R7", "bad write data half periods", m7, 0);
    chk(m8 == 0, "R8", "bhe_n mismatches", m8, 0);
    chk(m10 == 0, "R10", "bclk phase mismatches", m10, 0);
    @(negedge clk);
    chk(done == 1, "R5", "done after cycle", done, 1);
    chk(cs_n == 1, "R9", "cs_n after cycle", cs_n, 1);
    if (we) shadow[addr[7:0]] = wd;
    else chk(rdata == shadow[addr[7:0]], "R5", "read data", rdata, shadow[addr[7:0]]);
  endtask

  task automatic t_held_request();
    int gap = 0;
    @(negedge clk);
    req = 1; req_we = 0; req_addr = 16'h0033; req_bhe = 0;
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    while (cs_n) begin gap++; @(negedge clk); end
    req = 0;
    chk(gap >= 1, "R9", "idle half periods between held cycles", gap, 1);
    while (!cs_n) @(negedge clk);
    @(negedge clk);
    chk(rdata == shadow[8'h33], "R9", "second held cycle data", rdata, shadow[8'h33]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 257) ^ 16'h5a3c;
      shadow[i] = 16'(i * 257) ^ 16'h5a3c;
    end
    t_reset();
    while (rst) @(negedge clk);
    t_cycle(1, 16'h1212, 16'hbeef, 1);
    t_cycle(0, 16'h0012, 16'h0000, 0);
    t_cycle(0, 16'h0080, 16'h0000, 1);
    t_cycle(1, 16'h00ff, 16'h0001, 0);
    t_cycle(0, 16'h00ff, 16'hffff, 1);
    t_held_request();
    chk(clash == 0, "R4", "master drove lines with rd_n low", clash, 0);
    fin = 1;
  end
endmodule

module mux_bus_master_bench;
  logic clk = 0, rst = 1;
  bit   wd_fail = 0;
  always #2.5 clk = ~clk;

  mux_bus_rig #(.A(2), .B(2)) g22 (.clk(clk), .rst(rst));
  mux_bus_rig #(.A(1), .B(3)) g13 (.clk(clk), .rst(rst));
  mux_bus_rig #(.A(3), .B(1)) g31 (.clk(clk), .rst(rst));

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
  end

  initial begin
    int total, bad;
    for (int c = 0; c < 50000; c++) begin
      @(posedge clk);
      if (g22.fin && g13.fin && g31.fin) break;
    end
    if (!(g22.fin && g13.fin && g31.fin)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual unfinished expected finished");
    end
    total = g22.n_chk + g13.n_chk + g31.n_chk + (wd_fail ? 1 : 0);
    bad   = g22.n_bad + g13.n_bad + g31.n_bad + (wd_fail ? 1 : 0);
    $display("== %0d vectors applied, %0d miscompares ==", total, bad);
    $finish;
  end
endmodule